// File: doc/BRIEF.md
# Pipelined Multi-Predicate Path Predictor

This block predicts the outcomes of a fixed number of predicates inside each fetched instruction block. The outcomes come out in order, one per clock. The predictor sums signed saturating counters taken from several tables. Each table is indexed by hashing the block address with a table-specific length of a long global outcome history. The sign of the sum gives the predicted outcome. The magnitude of the sum, compared against a threshold, gives a confidence bit.

A start strobe with a block address launches one block. The block runs through three stages: hash, table access and sum. When all predicates are done, the block raises a one-cycle done strobe together with the predicted bitmap and the confidence bitmap. The global history is shifted speculatively with the predicted bits.

Each predicate's counters depend on the prediction just made for the predicate before it. The access stage therefore reads two neighbouring counters from every table. It selects one of them with the prediction that the sum stage is finishing in the same cycle, so dependent predicates issue back to back without a stall. A later resolution port delivers the actual outcomes of the block. It trains the counters that were used and repairs the history from a checkpoint taken when the block started.

Top module: `mpp_predictor`

## Requirements
- R1: After reset, done, pred_map and conf_map are 0, every counter is 0 and the history is all zeros. The first block therefore predicts all ones with all confidence bits 0.
- R2: start is accepted on a rising edge when the block is idle and upd_valid is low. done is then high for exactly one cycle, the cycle after the (N_PRED+2)-th rising edge following the accepting edge. pred_map and conf_map are updated in that same cycle.
- R3: start is ignored while a block is in progress and in any cycle where upd_valid is high. An ignored start produces no done, and it does not change the running block's results or the history.
- R4: For table t, predicate k and previous bit p, index bit j is the XOR of three things: every address bit b with b mod IDX_W = j, and every history bit h[b] with b < L_t and b mod IDX_W = j. This is then XORed with the value 2k+p. L_0 = 0 and L_t = HIST_LEN >> (N_TBL-1-t), which gives 0, 3, 6, 12, 25, 50, 100 and 200 by default. h[0] is the most recently shifted outcome.
- R5: For predicate 0, p is 0. For predicate k>0, p is the predicted value of predicate k-1 of the same block.
- R6: The sum is taken over the N_TBL indexed counters, each a signed 4-bit value. Bit k of pred_map is 1 when the sum for predicate k is 0 or more. Bit k of conf_map is 1 when the absolute sum exceeds 8.
- R7: When done is raised, the history shifts left by N_PRED. Predicate 0 lands in bit N_PRED-1 and predicate N_PRED-1 lands in bit 0.
- R8: A resolution applies when upd_valid is high while idle, with upd_taken bit k holding the actual outcome of predicate k of the most recent block. For every predicate that was mispredicted or not confident, each of its N_TBL counters moves one step toward the outcome. A counter saturates at +7 and -8.
- R9: A resolution sets the history to the checkpoint taken at that block's start, shifted by N_PRED, with the actual outcomes placed in the bit order of R7.
- R10: upd_valid is ignored while a block is in progress, before any block has completed, and when the latest block has already been resolved once.
- R11: pred_map and conf_map hold their values in every cycle in which done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch prediction of one block |
| blk_addr | input | ADDR_W | Address of the block being launched |
| upd_valid | input | 1 | Resolution strobe for the latest block |
| upd_taken | input | N_PRED | Actual predicate outcomes, bit k = predicate k |
| pred_map | output | N_PRED | Predicted predicate bitmap |
| conf_map | output | N_PRED | Confidence bitmap |
| done | output | 1 | One-cycle strobe marking new bitmaps |

## Verification
The bench keeps its own behavioural model of the counters and the history and compares the bitmaps each time a block completes. A wrong counter, index or history bit shows up as a flipped prediction or confidence bit, at the latest on the next block that reads the corrupted entry. Because a repaired or speculatively shifted history feeds every later index, a history fault tends to spread across many following blocks. A fault in stage timing or in the candidate selection shows up in the next done pulse: done arrives in the wrong cycle, or a bit k>0 takes the value that belongs to the other path.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

    typedef enum logic {ST_IDLE, ST_RUN} mpp_state_e;

    // History prefix used by table t: none for table 0, then doubling up to the full length.
    function automatic int hist_prefix(input int t, input int n_tbl, input int hlen);
        if (t == 0) return 0;
        return hlen >> (n_tbl - 1 - t);
    endfunction

    // One saturating step of a signed counter toward the resolved outcome.
    function automatic int sat_step(input int v, input logic up, input int lo, input int hi);
        if (up) return (v >= hi) ? v : v + 1;
        return (v <= lo) ? v : v - 1;
    endfunction

endpackage

// File: rtl/mpp_hash.sv
module mpp_hash #(
    parameter int ADDR_W   = 16,
    parameter int HIST_LEN = 200,
    parameter int IDX_W    = 6,
    parameter int N_TBL    = 8,
    parameter int POS_W    = 2
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [HIST_LEN-1:0]           hist,
    input  logic [POS_W-1:0]              pos,
    output logic [N_TBL-1:0][IDX_W-1:0]   base
);
    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        localparam int PLEN = mpp_pkg::hist_prefix(t, N_TBL, HIST_LEN);
        logic [IDX_W-1:0] fold;
        always_comb begin
            fold = IDX_W'({pos, 1'b0});
            for (int b = 0; b < ADDR_W; b++) fold[b % IDX_W] ^= addr[b];
            for (int b = 0; b < PLEN; b++)   fold[b % IDX_W] ^= hist[b];
        end
        assign base[t] = fold;
    end
endmodule

// File: rtl/mpp_tables.sv
module mpp_tables #(
    parameter int N_TBL  = 8,
    parameter int IDX_W  = 6,
    parameter int CTR_W  = 4,
    parameter int N_PRED = 4
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic [N_TBL-1:0][IDX_W-1:0]                rd_base,
    input  logic                                       rd_prev,
    output logic [N_TBL-1:0][CTR_W-1:0]                rd_ctr,
    output logic [N_TBL-1:0][IDX_W-1:0]                rd_idx,
    input  logic [N_PRED-1:0]                          wr_en,
    input  logic [N_PRED-1:0]                          wr_up,
    input  logic [N_PRED-1:0][N_TBL-1:0][IDX_W-1:0]    wr_idx
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int CTR_MAX = (1 << (CTR_W - 1)) - 1;
    localparam int CTR_MIN = -(1 << (CTR_W - 1));

    logic [CTR_W-1:0] mem [N_TBL][DEPTH];

    // Both candidates differ only in the index LSB; the late predicate picks one.
    for (genvar t = 0; t < N_TBL; t++) begin : g_rd
        logic [CTR_W-1:0] cand_lo, cand_hi;
        assign cand_lo   = mem[t][rd_base[t]];
        assign cand_hi   = mem[t][rd_base[t] ^ IDX_W'(1)];
        assign rd_ctr[t] = rd_prev ? cand_hi : cand_lo;
        assign rd_idx[t] = rd_base[t] ^ IDX_W'(rd_prev);
    end

    // Predicate positions occupy distinct index bits, so writes of one block never collide.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < N_TBL; t++)
                for (int d = 0; d < DEPTH; d++)
                    mem[t][d] <= '0;
        end else begin
            for (int k = 0; k < N_PRED; k++)
                for (int t = 0; t < N_TBL; t++)
                    if (wr_en[k])
                        mem[t][wr_idx[k][t]] <= CTR_W'(mpp_pkg::sat_step(
                            int'($signed(mem[t][wr_idx[k][t]])), wr_up[k], CTR_MIN, CTR_MAX));
        end
    end
endmodule

// File: rtl/mpp_sum.sv
module mpp_sum #(
    parameter int N_TBL   = 8,
    parameter int CTR_W   = 4,
    parameter int CONF_TH = 8
) (
    input  logic [N_TBL-1:0][CTR_W-1:0] ctr,
    output logic                        taken,
    output logic                        sure
);
    localparam int SUM_W = CTR_W + $clog2(N_TBL) + 1;

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] mag;

    always_comb begin
        total = '0;
        for (int t = 0; t < N_TBL; t++)
            total = total + {{(SUM_W - CTR_W){ctr[t][CTR_W-1]}}, ctr[t]};
        taken = ~total[SUM_W-1];
        mag   = total[SUM_W-1] ? (~total + SUM_W'(1)) : total;
        sure  = mag > SUM_W'(CONF_TH);
    end
endmodule

// File: rtl/mpp_predictor.sv
module mpp_predictor
    import mpp_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int HIST_LEN = 200,
    parameter int N_TBL    = 8,
    parameter int IDX_W    = 6,
    parameter int CTR_W    = 4,
    parameter int N_PRED   = 4,
    parameter int CONF_TH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic              upd_valid,
    input  logic [N_PRED-1:0] upd_taken,
    output logic [N_PRED-1:0] pred_map,
    output logic [N_PRED-1:0] conf_map,
    output logic              done
);
    localparam int POS_W = (N_PRED > 1) ? $clog2(N_PRED) : 1;

    typedef struct packed {
        logic             vld;
        logic [POS_W-1:0] pos;
    } slot_t;

    mpp_state_e                               state_q;
    logic [ADDR_W-1:0]                        addr_q;
    logic [HIST_LEN-1:0]                      ghr_q, ckpt_q, ghr_spec, ghr_fix;
    slot_t                                    iss_q, s2_q, s3_q;
    logic [N_TBL-1:0][IDX_W-1:0]              hash_base, s2_base, rd_idx, s3_idx;
    logic [N_TBL-1:0][CTR_W-1:0]              rd_ctr, s3_ctr;
    logic [N_PRED-1:0]                        stg_pred, stg_conf, nxt_pred, nxt_conf;
    logic [N_PRED-1:0][N_TBL-1:0][IDX_W-1:0]  rec_idx;
    logic [N_PRED-1:0]                        wr_en;
    logic                                     resolvable_q, s3_taken, s3_sure;
    logic                                     rd_prev, accept, resolve, last_rec;

    assign accept   = start && (state_q == ST_IDLE) && !upd_valid;
    assign resolve  = upd_valid && (state_q == ST_IDLE) && resolvable_q;
    assign rd_prev  = (s2_q.pos != '0) && s3_taken;
    assign last_rec = s3_q.vld && (s3_q.pos == POS_W'(N_PRED - 1));

    mpp_hash #(.ADDR_W(ADDR_W), .HIST_LEN(HIST_LEN), .IDX_W(IDX_W), .N_TBL(N_TBL), .POS_W(POS_W))
        u_hash (.addr(addr_q), .hist(ckpt_q), .pos(iss_q.pos), .base(hash_base));

    mpp_tables #(.N_TBL(N_TBL), .IDX_W(IDX_W), .CTR_W(CTR_W), .N_PRED(N_PRED))
        u_tables (.clk(clk), .rst(rst), .rd_base(s2_base), .rd_prev(rd_prev),
                  .rd_ctr(rd_ctr), .rd_idx(rd_idx), .wr_en(wr_en), .wr_up(upd_taken),
                  .wr_idx(rec_idx));

    mpp_sum #(.N_TBL(N_TBL), .CTR_W(CTR_W), .CONF_TH(CONF_TH))
        u_sum (.ctr(s3_ctr), .taken(s3_taken), .sure(s3_sure));

    always_comb begin
        nxt_pred = stg_pred;
        nxt_conf = stg_conf;
        nxt_pred[s3_q.pos] = s3_taken;
        nxt_conf[s3_q.pos] = s3_sure;
        ghr_spec = ckpt_q << N_PRED;
        ghr_fix  = ckpt_q << N_PRED;
        for (int k = 0; k < N_PRED; k++) begin
            ghr_spec[N_PRED-1-k] = nxt_pred[k];
            ghr_fix[N_PRED-1-k]  = upd_taken[k];
            wr_en[k] = resolve && (!conf_map[k] || (pred_map[k] != upd_taken[k]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            addr_q       <= '0;
            ghr_q        <= '0;
            ckpt_q       <= '0;
            iss_q        <= '0;
            s2_q         <= '0;
            s3_q         <= '0;
            s2_base      <= '0;
            s3_idx       <= '0;
            s3_ctr       <= '0;
            stg_pred     <= '0;
            stg_conf     <= '0;
            rec_idx      <= '0;
            resolvable_q <= 1'b0;
            pred_map     <= '0;
            conf_map     <= '0;
            done         <= 1'b0;
        end else begin
            // Stage 1: issue positions; hash is combinational from the issuing slot.
            if (accept) begin
                state_q <= ST_RUN;
                addr_q  <= blk_addr;
                ckpt_q  <= ghr_q;
                iss_q   <= '{vld: 1'b1, pos: '0};
            end else if (iss_q.vld) begin
                iss_q.pos <= iss_q.pos + POS_W'(1);
                iss_q.vld <= (iss_q.pos != POS_W'(N_PRED - 1));
            end
            // Stage 2: dual read, late select.
            s2_q    <= iss_q;
            s2_base <= hash_base;
            // Stage 3: sum and record.
            s3_q    <= s2_q;
            s3_ctr  <= rd_ctr;
            s3_idx  <= rd_idx;
            done    <= 1'b0;
            if (s3_q.vld) begin
                stg_pred <= nxt_pred;
                stg_conf <= nxt_conf;
                rec_idx[s3_q.pos] <= s3_idx;
                if (last_rec) begin
                    done         <= 1'b1;
                    pred_map     <= nxt_pred;
                    conf_map     <= nxt_conf;
                    ghr_q        <= ghr_spec;
                    state_q      <= ST_IDLE;
                    resolvable_q <= 1'b1;
                end
            end
            if (resolve) begin
                ghr_q        <= ghr_fix;
                resolvable_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mpp_checker.sv
module mpp_checker #(
    parameter int ADDR_W   = 16,
    parameter int HIST_LEN = 200,
    parameter int N_PRED   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                upd_valid,
    input logic                done,
    input logic [N_PRED-1:0]   pred_map,
    input logic [N_PRED-1:0]   conf_map,
    input logic                run,
    input logic [ADDR_W-1:0]   addr_q,
    input logic [HIST_LEN-1:0] ghr
);
    int since;

    always_ff @(posedge clk) begin
        if (rst)                            since <= 1000;
        else if (start && !run && !upd_valid) since <= 0;
        else if (run)                       since <= since + 1;
    end

    // R2: done is a single-cycle strobe
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: done arrives a fixed number of edges after the accepting edge
    a_r2_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (since == N_PRED + 2));

    // R3: a block in progress keeps its captured address
    a_r3_busy_keeps_addr: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(addr_q));

    // R10: history frozen while busy except at the completing edge
    a_r10_hist_frozen: assert property (@(posedge clk) disable iff (rst)
        (run && since != N_PRED + 1) |=> $stable(ghr));

    // R11: bitmaps change only alongside done
    a_r11_maps_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(pred_map) && $stable(conf_map)));
endmodule

bind mpp_predictor mpp_checker #(.ADDR_W(ADDR_W), .HIST_LEN(HIST_LEN), .N_PRED(N_PRED)) u_mpp_checker (
    .clk(clk), .rst(rst), .start(start), .upd_valid(upd_valid), .done(done),
    .pred_map(pred_map), .conf_map(conf_map),
    .run(state_q == mpp_pkg::ST_RUN), .addr_q(addr_q), .ghr(ghr_q));

// File: tb/test_mpp_predictor.sv
`timescale 1ns/1ps
module test_mpp_predictor;
    localparam int AW = 16;
    localparam int HL = 200;
    localparam int NT = 8;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] blk_addr = '0;
    logic          upd_valid = 1'b0;
    logic [NP-1:0] upd_taken = '0;
    logic [NP-1:0] pred_map, conf_map;
    logic          done;

    always #4 clk = ~clk;

    mpp_predictor i_mpp_predictor (
        .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr),
        .upd_valid(upd_valid), .upd_taken(upd_taken),
        .pred_map(pred_map), .conf_map(conf_map), .done(done));

    int checks = 0, errors = 0, cd = -1, conf_seen = 0;
    bit finished = 0;

    // Behavioural model state
    int            m_tbl [NT][64];
    bit [HL-1:0]   m_ghr, m_ckpt;
    bit [NP-1:0]   m_pred, m_conf;
    int            m_idx [NP][NT];
    bit            m_res_ok;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_index(int t, logic [AW-1:0] a, int k, int prev, bit [HL-1:0] h);
        int len, v, ch;
        len = (t == 0) ? 0 : (HL >> (NT - 1 - t));
        v = (2 * k) ^ prev;
        for (int c = 0; c < AW; c += 6) v ^= int'((a >> c) & 16'h3f);
        for (int c = 0; c < len; c += 6) begin
            ch = 0;
            for (int j = 0; j < 6; j++) if (c + j < len) ch |= int'(h[c + j]) << j;
            v ^= ch;
        end
        return v & 63;
    endfunction

    task automatic m_predict(input logic [AW-1:0] a);
        int prev, s;
        prev = 0;
        m_ckpt = m_ghr;
        for (int k = 0; k < NP; k++) begin
            s = 0;
            for (int t = 0; t < NT; t++) begin
                m_idx[k][t] = m_index(t, a, k, prev, m_ckpt);
                s += m_tbl[t][m_idx[k][t]];
            end
            m_pred[k] = (s >= 0);
            m_conf[k] = ((s < 0 ? -s : s) > 8);
            prev = m_pred[k];
        end
        m_ghr = m_ckpt << NP;
        for (int k = 0; k < NP; k++) m_ghr[NP-1-k] = m_pred[k];
        m_res_ok = 1;
    endtask

    task automatic m_resolve(input bit [NP-1:0] act);
        if (!m_res_ok) return;
        for (int k = 0; k < NP; k++)
            if (!m_conf[k] || m_pred[k] != act[k])
                for (int t = 0; t < NT; t++) begin
                    if (act[k] && m_tbl[t][m_idx[k][t]] < 7)   m_tbl[t][m_idx[k][t]]++;
                    if (!act[k] && m_tbl[t][m_idx[k][t]] > -8) m_tbl[t][m_idx[k][t]]--;
                end
        m_ghr = m_ckpt << NP;
        for (int k = 0; k < NP; k++) m_ghr[NP-1-k] = act[k];
        m_res_ok = 0;
    endtask

    // One clock: sample at the falling edge and compare with the model.
    task automatic cyc();
        bit exp_done;
        @(negedge clk);
        if (cd > 0) cd--;
        exp_done = (cd == 0);
        chk(done == exp_done, "R2 R3 done timing", int'(done), int'(exp_done));
        if (exp_done) begin
            chk(pred_map == m_pred, "R4 R5 R6 R7 R8 R9 pred_map", int'(pred_map), int'(m_pred));
            chk(conf_map == m_conf, "R6 R8 conf_map", int'(conf_map), int'(m_conf));
            if (conf_map != 0) conf_seen++;
            cd = -1;
        end
    endtask

    task automatic launch(input logic [AW-1:0] a);
        start = 1'b1;
        blk_addr = a;
        m_predict(a);
        cd = NP + 3;
        cyc();
        start = 1'b0;
    endtask

    task automatic wait_done();
        repeat (NP + 2) cyc();
    endtask

    task automatic resolve(input bit [NP-1:0] act, input bit model_it);
        upd_valid = 1'b1;
        upd_taken = act;
        if (model_it) m_resolve(act);
        cyc();
        upd_valid = 1'b0;
    endtask

    initial begin
        for (int t = 0; t < NT; t++) for (int d = 0; d < 64; d++) m_tbl[t][d] = 0;
        m_ghr = '0; m_ckpt = '0; m_pred = '0; m_conf = '0; m_res_ok = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && pred_map == 0 && conf_map == 0, "R1 reset outputs",
            int'({done, pred_map, conf_map}), 0);

        // R10: resolution before any block is ignored
        resolve(4'b0000, 1'b1);
        launch(16'h1234);
        wait_done();
        chk(pred_map == 4'hF && conf_map == 4'h0, "R1 R10 first block all ones",
            int'({pred_map, conf_map}), 'hF0);

        // R8: train all down; R5: dependent predicates pick other path entries
        resolve(4'b0000, 1'b1);
        resolve(4'b1111, 1'b1);          // R10: second resolution ignored
        launch(16'h1234);
        wait_done();
        chk(pred_map == 4'b1010, "R5 R8 R10 dependent selection", int'(pred_map), 'hA);
        chk(conf_map == 4'b0000, "R6 weak after one step", int'(conf_map), 0);

        // R3: start during a running block is ignored
        launch(16'h0F0F);
        cyc();
        start = 1'b1; blk_addr = 16'hBEEF;
        cyc();
        start = 1'b0;
        repeat (NP) cyc();
        repeat (3) cyc();

        // R10: update while busy is ignored
        launch(16'h5A5A);
        upd_valid = 1'b1; upd_taken = 4'b0110;
        cyc();
        upd_valid = 1'b0;
        repeat (NP + 1) cyc();
        resolve(4'b1001, 1'b1);

        // R3: start together with upd_valid is ignored, update applies
        launch(16'h0077);
        wait_done();
        start = 1'b1; blk_addr = 16'h1111;
        resolve(4'b0011, 1'b1);
        start = 1'b0;
        repeat (NP + 4) cyc();

        // Long run, back-to-back blocks, outcomes tied to address
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            bit [NP-1:0] act;
            a = 16'h0100 * AW'(i % 4) + 16'h0035;
            act = bit'(i % 4 == 0) ? 4'b1010 : ((i % 4 == 1) ? 4'b0110 : ((i % 4 == 2) ? 4'b1111 : 4'b0001));
            launch(a);
            wait_done();
            if (i % 5 != 4) resolve(act, 1'b1);
        end
        chk(conf_seen > 0, "R6 confidence reached", conf_seen, 1);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule